// File: doc/BRIEF.md
# Round-Robin Monitor Conversion Post-Processor

This block runs one shared analog-to-digital converter across six monitor channels. Channel 0 is the die temperature, channel 1 is the supply voltage, channels 2 and 4 are the power monitors of transmitters 0 and 1, and channels 3 and 5 are their bias monitors. The block drives the channel select and holds it while a conversion runs. When the converter pulses its done strobe with a 16-bit left-justified raw code, the block handles that result for the selected channel. It scales the code by a programmable logical right shift, which applies to the four external monitors only. It stores the scaled value in a six-entry measurement file and updates four threshold flags for the channel: high alarm, high warning, low warning and low alarm. It then advances the select.

Two extra behaviours serve the start-up of the module. First, while the supply-low check is enabled, the block cycles between temperature and supply only. It leaves that reduced cycle when a supply reading is no longer below the supply low-alarm threshold, and it enters it again when both transmitters open a transmit-disable window at the same time. Second, while a transmitter's extended disable window is open, the low flags of that transmitter's power and bias channels are kept from being set, so a control loop that is still settling raises no false low flags. A configuration input chooses whether flags are sticky or follow the latest result.

Top module: `adc_rr_monitor`

## Requirements
- R1: After reset `sel_ch` is 0. It changes only on a clock edge that samples `conv_done` high, and in the full cycle it advances 0,1,2,3,4,5 and then wraps to 0.
- R2: The value stored for a channel is its raw code shifted right logically, with zeros entering at the MSB. For channel 2+k (k = 0..3) the shift amount is `shift_cfg[3k+2:3k]`. Channels 0 and 1 are stored unshifted. Entry c of `meas` is `meas[16c+15:16c]` and changes only when a conversion of channel c completes.
- R3: The flags are computed from the shifted value v and the selected channel's thresholds, taken from slice c of each threshold port. High alarm is v > `thr_hi_alm`, high warning is v > `thr_hi_wrn`, low warning is v < `thr_lo_wrn`, and low alarm is v < `thr_lo_alm`. Channels 1 to 5 compare unsigned.
- R4: Channel 0 (temperature) compares its value and thresholds as two's-complement numbers.
- R5: Bit c of each flag output belongs to channel c. With `latch_mode` low, a conversion of channel c replaces its four flags with the new compare results and leaves every other channel's flags unchanged.
- R6: With `latch_mode` high, a conversion can set a flag but never clear it. Only reset clears a flag.
- R7: Reset clears every measurement and every flag, and `pwr_hold` then equals `vcc_lo_en`.
- R8: With `vcc_lo_en` high after reset, `pwr_hold` is high and the select alternates 0,1,0,1. When a channel-1 conversion gives a low-alarm compare that is false, `pwr_hold` drops and the next channel is 2.
- R9: With `vcc_lo_en` high, a clock edge where both bits of `txd_ext` are high after a cycle where they were not both high raises `pwr_hold`. The conversion that completes next then hands over to channel 0, or to channel 1 if it was a channel-0 conversion. With `vcc_lo_en` low this event does nothing.
- R10: While `txd_ext[0]` is high, a conversion of channel 2 or 3 sets neither its low alarm nor its low warning. `txd_ext[1]` does the same for channels 4 and 5. High flags are never affected by these windows.
- R11: With `vcc_lo_en` low, the full cycle runs from reset and `pwr_hold` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: conversion of the selected channel is complete |
| conv_data | input | 16 | Raw left-justified conversion code |
| sel_ch | output | 3 | Channel the converter should sample |
| shift_cfg | input | 12 | Right-shift amounts, 3 bits each for channels 2 to 5 |
| thr_hi_alm | input | 96 | High alarm thresholds, 16 bits per channel |
| thr_hi_wrn | input | 96 | High warning thresholds |
| thr_lo_wrn | input | 96 | Low warning thresholds |
| thr_lo_alm | input | 96 | Low alarm thresholds |
| latch_mode | input | 1 | 1: sticky flags, 0: flags follow the latest result |
| vcc_lo_en | input | 1 | Enables supply-low gating and the reduced cycle |
| txd_ext | input | 2 | Extended transmit-disable window per transmitter |
| pwr_hold | output | 1 | Supply-low gating active (reduced cycle) |
| meas | output | 96 | Measurement file, 16 bits per channel |
| alm_hi | output | 6 | High alarm flags |
| wrn_hi | output | 6 | High warning flags |
| wrn_lo | output | 6 | Low warning flags |
| alm_lo | output | 6 | Low alarm flags |

## Verification
The outputs are registered, with no extra pipeline stage. The measurement entry, the four flags, the next channel select and `pwr_hold` all settle on the first rising edge that samples `conv_done` high. A gating change caused by both disable windows opening shows on the first edge after the windows open. The bench drives each stimulus on a falling edge and compares the ports at the next falling edge, one rising edge later. It checks the full flag vectors, so a change to any channel other than the converted one is also caught. Idle stretches hold `conv_done` low for several cycles and confirm that the select and the measurements stay where they were.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;
    localparam int NCH  = 6;
    localparam int NEXT = 4;
    localparam int CHW  = 3;

    typedef enum logic [CHW-1:0] {
        CH_TEMP  = 3'd0,
        CH_VCC   = 3'd1,
        CH_PWR0  = 3'd2,
        CH_BIAS0 = 3'd3,
        CH_PWR1  = 3'd4,
        CH_BIAS1 = 3'd5
    } chan_e;

    typedef struct packed {
        logic hi_alm;
        logic hi_wrn;
        logic lo_wrn;
        logic lo_alm;
    } lvl_t;
endpackage

// File: rtl/adcmon_shift.sv
module adcmon_shift
    import adcmon_pkg::*;
#(
    parameter int DW  = 16,
    parameter int SHW = 3
) (
    input  logic [DW-1:0]        raw,
    input  logic [CHW-1:0]       ch,
    input  logic [NEXT*SHW-1:0]  cfg,
    output logic [DW-1:0]        res
);
    logic [SHW-1:0] amt;

    always_comb begin
        amt = '0;
        for (int k = 0; k < NEXT; k++) begin
            if (ch == CHW'(k + 2)) amt = cfg[k*SHW +: SHW];
        end
        res = raw >> amt;
    end
endmodule

// File: rtl/adcmon_cmp.sv
module adcmon_cmp
    import adcmon_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] t_ha,
    input  logic [DW-1:0] t_hw,
    input  logic [DW-1:0] t_lw,
    input  logic [DW-1:0] t_la,
    input  logic          is_signed,
    output lvl_t          lvl
);
    always_comb begin
        if (is_signed) begin
            lvl.hi_alm = $signed(val) > $signed(t_ha);
            lvl.hi_wrn = $signed(val) > $signed(t_hw);
            lvl.lo_wrn = $signed(val) < $signed(t_lw);
            lvl.lo_alm = $signed(val) < $signed(t_la);
        end else begin
            lvl.hi_alm = val > t_ha;
            lvl.hi_wrn = val > t_hw;
            lvl.lo_wrn = val < t_lw;
            lvl.lo_alm = val < t_la;
        end
    end
endmodule

// File: rtl/adcmon_seq.sv
module adcmon_seq
    import adcmon_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_done,
    input  logic           vcc_lo_en,
    input  logic           txd_both,
    input  logic           vcc_low_hit,
    output logic [CHW-1:0] sel_o,
    output logic           hold_o
);
    typedef struct packed {
        logic [CHW-1:0] sel;
        logic           hold;
        logic           both;
    } seq_t;

    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    seq_t seq_d, seq_q;
    logic both_rise;

    always_comb begin
        seq_d      = seq_q;
        seq_d.both = txd_both;
        both_rise  = txd_both & ~seq_q.both;
        if (vcc_lo_en && both_rise) begin
            seq_d.hold = 1'b1;
        end else if (conv_done && seq_q.sel == CH_VCC && (!vcc_lo_en || !vcc_low_hit)) begin
            seq_d.hold = 1'b0;
        end
        if (conv_done) begin
            if (seq_d.hold && vcc_lo_en) begin
                seq_d.sel = (seq_q.sel == CH_TEMP) ? CH_VCC : CH_TEMP;
            end else begin
                seq_d.sel = (seq_q.sel == LAST) ? CH_TEMP : seq_q.sel + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.sel  <= CH_TEMP;
            seq_q.hold <= 1'b1;
            seq_q.both <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sel_o  = seq_q.sel;
    assign hold_o = seq_q.hold & vcc_lo_en;

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.sel <= LAST); // R1
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(sel_o)); // R1
    AST_SEL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && sel_o == LAST) |=> sel_o == CH_TEMP); // R1
    AST_REDUCED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && hold_o && sel_o == CH_TEMP) |=> sel_o == CH_VCC); // R8
endmodule

// File: rtl/adc_rr_monitor.sv
module adc_rr_monitor
    import adcmon_pkg::*;
#(
    parameter int DW  = 16,
    parameter int SHW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_done,
    input  logic [DW-1:0]       conv_data,
    output logic [CHW-1:0]      sel_ch,
    input  logic [NEXT*SHW-1:0] shift_cfg,
    input  logic [NCH*DW-1:0]   thr_hi_alm,
    input  logic [NCH*DW-1:0]   thr_hi_wrn,
    input  logic [NCH*DW-1:0]   thr_lo_wrn,
    input  logic [NCH*DW-1:0]   thr_lo_alm,
    input  logic                latch_mode,
    input  logic                vcc_lo_en,
    input  logic [1:0]          txd_ext,
    output logic                pwr_hold,
    output logic [NCH*DW-1:0]   meas,
    output logic [NCH-1:0]      alm_hi,
    output logic [NCH-1:0]      wrn_hi,
    output logic [NCH-1:0]      wrn_lo,
    output logic [NCH-1:0]      alm_lo
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] meas;
        logic [NCH-1:0]         ah;
        logic [NCH-1:0]         wh;
        logic [NCH-1:0]         wl;
        logic [NCH-1:0]         al;
    } mon_t;

    mon_t          mon_d, mon_q;
    logic [DW-1:0] shv;
    logic [DW-1:0] t_ha, t_hw, t_lw, t_la;
    lvl_t          lvl;
    logic          lo_mask;

    adcmon_shift #(.DW(DW), .SHW(SHW)) u_shift (
        .raw (conv_data),
        .ch  (sel_ch),
        .cfg (shift_cfg),
        .res (shv)
    );

    always_comb begin
        t_ha = thr_hi_alm[int'(sel_ch)*DW +: DW];
        t_hw = thr_hi_wrn[int'(sel_ch)*DW +: DW];
        t_lw = thr_lo_wrn[int'(sel_ch)*DW +: DW];
        t_la = thr_lo_alm[int'(sel_ch)*DW +: DW];
    end

    adcmon_cmp #(.DW(DW)) u_cmp (
        .val       (shv),
        .t_ha      (t_ha),
        .t_hw      (t_hw),
        .t_lw      (t_lw),
        .t_la      (t_la),
        .is_signed (sel_ch == CH_TEMP),
        .lvl       (lvl)
    );

    adcmon_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .vcc_lo_en   (vcc_lo_en),
        .txd_both    (&txd_ext),
        .vcc_low_hit (lvl.lo_alm),
        .sel_o       (sel_ch),
        .hold_o      (pwr_hold)
    );

    // channels 2,3 belong to transmitter 0; 4,5 to transmitter 1
    assign lo_mask = sel_ch[2] ? txd_ext[1] : (sel_ch[1] & txd_ext[0]);

    always_comb begin
        mon_d = mon_q;
        if (conv_done && sel_ch < CHW'(NCH)) begin
            mon_d.meas[sel_ch] = shv;
            mon_d.ah[sel_ch] = lvl.hi_alm | (latch_mode & mon_q.ah[sel_ch]);
            mon_d.wh[sel_ch] = lvl.hi_wrn | (latch_mode & mon_q.wh[sel_ch]);
            mon_d.wl[sel_ch] = (lvl.lo_wrn & ~lo_mask) | (latch_mode & mon_q.wl[sel_ch]);
            mon_d.al[sel_ch] = (lvl.lo_alm & ~lo_mask) | (latch_mode & mon_q.al[sel_ch]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign meas   = mon_q.meas;
    assign alm_hi = mon_q.ah;
    assign wrn_hi = mon_q.wh;
    assign wrn_lo = mon_q.wl;
    assign alm_lo = mon_q.al;

    AST_MEAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(meas)); // R2

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_STICKY_HI: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_mode && alm_hi[c]) |=> alm_hi[c]); // R6
        AST_STICKY_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_mode && alm_lo[c]) |=> alm_lo[c]); // R6
        if (c >= 2) begin : g_ext
            localparam int TX = (c >= 4) ? 1 : 0;
            AST_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
                (conv_done && sel_ch == CHW'(c) && txd_ext[TX] && !latch_mode)
                |=> (!alm_lo[c] && !wrn_lo[c])); // R10
        end
    end
endmodule

// File: tb/test_adc_rr_monitor.sv
module test_adc_rr_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic [2:0] sel_ch;
    logic [11:0] shift_cfg;
    logic [95:0] thr_hi_alm, thr_hi_wrn, thr_lo_wrn, thr_lo_alm;
    logic latch_mode = 1'b0;
    logic vcc_lo_en = 1'b0;
    logic [1:0] txd_ext = 2'b00;
    logic pwr_hold;
    logic [95:0] meas;
    logic [5:0] alm_hi, wrn_hi, wrn_lo, alm_lo;

    logic [15:0] t_ha [NCH];
    logic [15:0] t_hw [NCH];
    logic [15:0] t_lw [NCH];
    logic [15:0] t_la [NCH];
    logic [2:0]  sh   [4];
    logic [15:0] benign [NCH];

    logic [15:0] m_meas [NCH];
    logic [5:0]  m_ah, m_wh, m_wl, m_al;
    int          m_sel;
    bit          m_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            thr_hi_alm[c*16 +: 16] = t_ha[c];
            thr_hi_wrn[c*16 +: 16] = t_hw[c];
            thr_lo_wrn[c*16 +: 16] = t_lw[c];
            thr_lo_alm[c*16 +: 16] = t_la[c];
        end
        for (int k = 0; k < 4; k++) shift_cfg[k*3 +: 3] = sh[k];
    end

    adc_rr_monitor i_adc_rr_monitor (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .sel_ch(sel_ch), .shift_cfg(shift_cfg),
        .thr_hi_alm(thr_hi_alm), .thr_hi_wrn(thr_hi_wrn),
        .thr_lo_wrn(thr_lo_wrn), .thr_lo_alm(thr_lo_alm),
        .latch_mode(latch_mode), .vcc_lo_en(vcc_lo_en), .txd_ext(txd_ext),
        .pwr_hold(pwr_hold), .meas(meas),
        .alm_hi(alm_hi), .wrn_hi(wrn_hi), .wrn_lo(wrn_lo), .alm_lo(alm_lo)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_shift(int ch, logic [15:0] raw);
        if (ch >= 2) return raw >> sh[ch-2];
        return raw;
    endfunction

    function automatic bit f_gt(int ch, logic [15:0] a, logic [15:0] b);
        if (ch == 0) return $signed(a) > $signed(b);
        return a > b;
    endfunction

    task automatic check_all(input string tag);
        check(sel_ch == 3'(m_sel), tag, "sel_ch", 96'(sel_ch), 96'(m_sel));
        check(pwr_hold == (m_hold & vcc_lo_en), tag, "pwr_hold", 96'(pwr_hold), 96'(m_hold & vcc_lo_en));
        check(alm_hi == m_ah, tag, "alm_hi", 96'(alm_hi), 96'(m_ah));
        check(wrn_hi == m_wh, tag, "wrn_hi", 96'(wrn_hi), 96'(m_wh));
        check(wrn_lo == m_wl, tag, "wrn_lo", 96'(wrn_lo), 96'(m_wl));
        check(alm_lo == m_al, tag, "alm_lo", 96'(alm_lo), 96'(m_al));
    endtask

    task automatic conv(input logic [15:0] raw, input string tag);
        int ch = m_sel;
        logic [15:0] v = f_shift(ch, raw);
        bit ha = f_gt(ch, v, t_ha[ch]);
        bit hw = f_gt(ch, v, t_hw[ch]);
        bit lw = f_gt(ch, t_lw[ch], v);
        bit la = f_gt(ch, t_la[ch], v);
        bit la_raw = la;
        bit mask = (ch >= 2) && txd_ext[(ch >= 4) ? 1 : 0];
        if (mask) begin lw = 0; la = 0; end
        m_meas[ch] = v;
        m_ah[ch] = ha | (latch_mode & m_ah[ch]);
        m_wh[ch] = hw | (latch_mode & m_wh[ch]);
        m_wl[ch] = lw | (latch_mode & m_wl[ch]);
        m_al[ch] = la | (latch_mode & m_al[ch]);
        if (ch == 1 && (!vcc_lo_en || !la_raw)) m_hold = 0;
        if (m_hold && vcc_lo_en) m_sel = (ch == 0) ? 1 : 0;
        else m_sel = (ch == 5) ? 0 : ch + 1;
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = raw;
        @(negedge clk);
        conv_done = 1'b0;
        check(meas[ch*16 +: 16] == m_meas[ch], tag, "meas", 96'(meas[ch*16 +: 16]), 96'(m_meas[ch]));
        check_all(tag);
    endtask

    task automatic goto_ch(input int ch, input string tag);
        int guard = 0;
        while (m_sel != ch && guard < 12) begin
            conv(benign[m_sel], tag);
            guard++;
        end
    endtask

    task automatic set_txd(input logic [1:0] v, input string tag);
        bit old_both;
        @(negedge clk);
        old_both = &txd_ext;
        txd_ext = v;
        @(negedge clk);
        if (vcc_lo_en && (&v) && !old_both) m_hold = 1;
        check_all(tag);
    endtask

    task automatic do_reset(input bit vlo, input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        conv_done = 1'b0;
        txd_ext = 2'b00;
        vcc_lo_en = vlo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) m_meas[c] = '0;
        m_ah = '0; m_wh = '0; m_wl = '0; m_al = '0;
        m_sel = 0; m_hold = 1;
        @(negedge clk);
        check(meas == '0, tag, "meas after reset", meas, '0);
        check_all(tag);
    endtask

    task automatic t_rotation();
        do_reset(1'b0, "R7");
        conv(16'h0100, "R1");
        conv(16'h8000, "R1");
        conv(16'hFFFF, "R2");
        check(meas[2*16 +: 16] == 16'h1FFF, "R2", "shift3", 96'(meas[2*16 +: 16]), 96'h1FFF);
        conv(16'h5555, "R2");
        conv(16'hFFFF, "R2");
        check(meas[4*16 +: 16] == 16'h01FF, "R2", "shift7 zero fill", 96'(meas[4*16 +: 16]), 96'h01FF);
        conv(16'h8001, "R2");
        check(sel_ch == 3'd0, "R1", "wrap", 96'(sel_ch), 96'd0);
        conv(16'h1234, "R1");
        begin
            logic [95:0] m0 = meas;
            logic [2:0]  s0 = sel_ch;
            repeat (4) @(negedge clk);
            check(sel_ch == s0, "R1", "idle sel", 96'(sel_ch), 96'(s0));
            check(meas == m0, "R2", "idle meas", meas, m0);
        end
        check(pwr_hold == 1'b0, "R11", "hold low", 96'(pwr_hold), 96'd0);
    endtask

    task automatic t_compare();
        t_ha[2] = 16'h1000; t_hw[2] = 16'h0800; t_lw[2] = 16'h0100; t_la[2] = 16'h0080;
        goto_ch(2, "R3");
        conv(16'h6000, "R3");
        check(wrn_hi[2] && !alm_hi[2], "R3", "shifted 0C00 warn only", 96'({alm_hi[2], wrn_hi[2]}), 96'b01);
        goto_ch(2, "R3");
        conv(16'h0600, "R3");
        check(wrn_lo[2] && !alm_lo[2], "R3", "shifted 00C0 low warn", 96'({alm_lo[2], wrn_lo[2]}), 96'b01);
        goto_ch(2, "R3");
        conv(16'h0300, "R3");
        check(wrn_lo[2] && alm_lo[2], "R3", "shifted 0060 low alarm", 96'({alm_lo[2], wrn_lo[2]}), 96'b11);
    endtask

    task automatic t_signed_live();
        latch_mode = 1'b0;
        goto_ch(0, "R4");
        conv(16'hC000, "R4");
        check(alm_lo[0] && !alm_hi[0], "R4", "negative temp", 96'({alm_hi[0], alm_lo[0]}), 96'b01);
        goto_ch(0, "R4");
        conv(16'h3800, "R4");
        check(wrn_hi[0] && !alm_hi[0] && !alm_lo[0], "R4", "warm temp", 96'({alm_hi[0], wrn_hi[0], alm_lo[0]}), 96'b010);
        goto_ch(0, "R5");
        conv(16'h1000, "R5");
        check({alm_hi[0], wrn_hi[0], wrn_lo[0], alm_lo[0]} == 4'b0000, "R5", "live clear",
              96'({alm_hi[0], wrn_hi[0], wrn_lo[0], alm_lo[0]}), 96'd0);
    endtask

    task automatic t_latched();
        latch_mode = 1'b1;
        goto_ch(0, "R6");
        conv(16'h7000, "R6");
        goto_ch(0, "R6");
        conv(16'h1000, "R6");
        check(alm_hi[0] && wrn_hi[0], "R6", "sticky high", 96'({alm_hi[0], wrn_hi[0]}), 96'b11);
        latch_mode = 1'b0;
    endtask

    task automatic t_powerup();
        do_reset(1'b1, "R7");
        check(pwr_hold == 1'b1, "R8", "hold at start", 96'(pwr_hold), 96'd1);
        conv(16'h1000, "R8");
        conv(16'h0800, "R8");
        check(sel_ch == 3'd0 && pwr_hold, "R8", "low supply back to temp", 96'({pwr_hold, sel_ch}), 96'({1'b1, 3'd0}));
        conv(16'h1000, "R8");
        conv(16'h8000, "R8");
        check(sel_ch == 3'd2 && !pwr_hold, "R8", "release to ch2", 96'({pwr_hold, sel_ch}), 96'({1'b0, 3'd2}));
    endtask

    task automatic t_both_txd();
        set_txd(2'b11, "R9");
        check(pwr_hold == 1'b1, "R9", "both windows", 96'(pwr_hold), 96'd1);
        conv(16'h4000, "R9");
        check(sel_ch == 3'd0, "R9", "to temp", 96'(sel_ch), 96'd0);
        conv(16'h1000, "R9");
        conv(16'h8000, "R9");
        check(!pwr_hold && sel_ch == 3'd2, "R9", "exit", 96'({pwr_hold, sel_ch}), 96'({1'b0, 3'd2}));
        set_txd(2'b00, "R9");
        vcc_lo_en = 1'b0;
        set_txd(2'b11, "R9");
        check(pwr_hold == 1'b0, "R9", "no effect when disabled", 96'(pwr_hold), 96'd0);
        set_txd(2'b00, "R9");
    endtask

    task automatic t_mask();
        latch_mode = 1'b0;
        set_txd(2'b01, "R10");
        goto_ch(2, "R10");
        conv(16'h0000, "R10");
        check(!alm_lo[2] && !wrn_lo[2], "R10", "ch2 low masked", 96'({alm_lo[2], wrn_lo[2]}), 96'd0);
        conv(16'hFFFF, "R10");
        check(alm_hi[3] && wrn_hi[3], "R10", "ch3 high unmasked", 96'({alm_hi[3], wrn_hi[3]}), 96'b11);
        conv(16'h0000, "R10");
        check(alm_lo[4] && wrn_lo[4], "R10", "ch4 other window", 96'({alm_lo[4], wrn_lo[4]}), 96'b11);
        set_txd(2'b00, "R10");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            t_ha[c] = 16'hC000; t_hw[c] = 16'hA000; t_lw[c] = 16'h2000; t_la[c] = 16'h1000;
        end
        t_ha[0] = 16'h4000; t_hw[0] = 16'h3000; t_lw[0] = 16'hF000; t_la[0] = 16'hE000;
        sh[0] = 3'd3; sh[1] = 3'd0; sh[2] = 3'd7; sh[3] = 3'd1;
        benign[0] = 16'h1000; benign[1] = 16'h8000; benign[2] = 16'h4000;
        benign[3] = 16'h5000; benign[4] = 16'hFFFF; benign[5] = 16'h8000;
        t_rotation();
        t_compare();
        t_signed_live();
        t_latched();
        t_powerup();
        t_both_txd();
        t_mask();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule